// File: doc/BRIEF.md
# Pad State Hold Across Deep Sleep

This block keeps a chip's pad configuration steady through a deep-sleep period and the reset that ends it. When the sleep entry strobe arrives, it copies the live per-pin output-enable and output-data registers, plus an oscillator-enable bit, into a retained copy and raises a hold flag. While the hold flag is up, the pads and the oscillator enable are driven from that retained copy. This holds through the wake, the reset that follows it, and any later software writes to the live registers. Software lowers the hold flag with a release strobe, and from that edge on the pads follow the live registers.

The way the hold ends depends on the reset cause. A brown-out event drops the hold at once, wipes the retained copy and clears the two context registers. A reset-pin event keeps the hold flag and the context registers, but forces every pin to its reset state (input, not driving) until software releases. During that time the oscillator keeps its retained setting. A full power-on reset (`rst`) clears everything. The two context registers let firmware save words that are still there after a non-power wake.

Top module: `pad_hold_keeper`

## Requirements
- R1: `sleep_i`, with no higher-priority event in that cycle, sets `release_o` and enters sleep at the next edge. If the hold was low, it also captures the live enable, data and oscillator bits. If the hold was already high, the retained copy is kept.
- R2: While the hold is up and not forced, `pad_oe_o` equals the captured enable and `pad_do_o` equals the captured data ANDed with the captured enable, whatever is written to the live registers.
- R3: `wake_i` ends sleep and resets the live enable, data and oscillator bits to 0. The pads keep their retained state after the wake.
- R4: `rel_clr_i` while awake lowers `release_o`, and at that same edge the pads take the live enable and live data ANDed with enable. `rel_clr_i` has no effect while asleep.
- R5: `osc_en_o` is the retained oscillator bit while the hold is up and the live bit afterwards. Setting the live bit to 1 before release keeps `osc_en_o` at 1 through the release.
- R6: `bor_i` lowers the hold, clears the retained copy, the live registers and both context registers, and ends sleep. The pads then show the live (zero) state.
- R7: `pin_rst_i` keeps `release_o` and the context registers and resets the live registers. If the hold is up, it forces `pad_oe_o` and `pad_do_o` to 0 until release while `osc_en_o` keeps the retained value.
- R8: Context register i (bits i*CTX_W upward of `ctx_o`) takes `ctx_wd_i` when `ctx_we_i[i]` is high in a cycle with no event. Only `rst` or `bor_i` changes it otherwise, so it survives sleep, wake and pin reset.
- R9: A synchronous `rst` clears all outputs and state to 0 at the next edge.
- R10: Events have priority `rst` > `bor_i` > `pin_rst_i` > `sleep_i` > `wake_i`. In any cycle with an event, live writes, context writes and `rel_clr_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| bor_i | input | 1 | Brown-out event strobe |
| pin_rst_i | input | 1 | Reset-pin event strobe |
| sleep_i | input | 1 | Deep-sleep entry strobe |
| wake_i | input | 1 | Wake event strobe |
| rel_clr_i | input | 1 | Software release strobe |
| oe_we_i | input | 1 | Live output-enable write strobe |
| oe_wd_i | input | PINS | Live output-enable write data (1 = drive) |
| lat_we_i | input | 1 | Live output-data write strobe |
| lat_wd_i | input | PINS | Live output-data write data |
| osc_we_i | input | 1 | Live oscillator-enable write strobe |
| osc_wd_i | input | 1 | Live oscillator-enable write data |
| ctx_we_i | input | CTX_N | Per-register context write strobes |
| ctx_wd_i | input | CTX_W | Context write data |
| ctx_o | output | CTX_N*CTX_W | Context register contents |
| pad_oe_o | output | PINS | Per-pin output enable |
| pad_do_o | output | PINS | Per-pin output data |
| osc_en_o | output | 1 | Oscillator enable |
| release_o | output | 1 | Hold flag |

## Verification
The bench writes the live registers while asleep, and again after wake but before release. A design that let these writes through would move the pads early. It fires a pin reset while the hold is up and checks that the pins go to input while the context words and the oscillator setting stay. A design that treated a pin reset like a brown-out would lose both. It sets the live oscillator bit before release and checks that `osc_en_o` never drops, and it sends a release strobe during sleep, which must be ignored. It also drives events together with writes, where any wrong priority shows up as a changed context word or pad.

// File: rtl/padhold_pkg.sv
package padhold_pkg;
  typedef enum logic [2:0] {
    EV_NONE   = 3'd0,
    EV_BOR    = 3'd1,
    EV_PINRST = 3'd2,
    EV_SLEEP  = 3'd3,
    EV_WAKE   = 3'd4
  } hold_ev_t;
endpackage

// File: rtl/padhold_evt.sv
module padhold_evt
  import padhold_pkg::*;
(
  input  logic     bor_i,
  input  logic     pin_rst_i,
  input  logic     sleep_i,
  input  logic     wake_i,
  output hold_ev_t ev_o
);
  always_comb begin
    if (bor_i)          ev_o = EV_BOR;
    else if (pin_rst_i) ev_o = EV_PINRST;
    else if (sleep_i)   ev_o = EV_SLEEP;
    else if (wake_i)    ev_o = EV_WAKE;
    else                ev_o = EV_NONE;
  end
endmodule

// File: rtl/padhold_live.sv
module padhold_live
  import padhold_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  hold_ev_t        ev,
  input  logic            oe_we_i,
  input  logic [PINS-1:0] oe_wd_i,
  input  logic            lat_we_i,
  input  logic [PINS-1:0] lat_wd_i,
  input  logic            osc_we_i,
  input  logic            osc_wd_i,
  output logic [PINS-1:0] oe_q,
  output logic [PINS-1:0] lat_q,
  output logic            osc_q,
  output logic [PINS-1:0] oe_d,
  output logic [PINS-1:0] lat_d,
  output logic            osc_d
);
  always_comb begin
    oe_d  = oe_q;
    lat_d = lat_q;
    osc_d = osc_q;
    case (ev)
      EV_BOR, EV_PINRST, EV_WAKE: begin
        oe_d  = '0;
        lat_d = '0;
        osc_d = 1'b0;
      end
      EV_NONE: begin
        if (oe_we_i)  oe_d  = oe_wd_i;
        if (lat_we_i) lat_d = lat_wd_i;
        if (osc_we_i) osc_d = osc_wd_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= '0;
      lat_q <= '0;
      osc_q <= 1'b0;
    end else begin
      oe_q  <= oe_d;
      lat_q <= lat_d;
      osc_q <= osc_d;
    end
  end
endmodule

// File: rtl/padhold_ctrl.sv
module padhold_ctrl
  import padhold_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  hold_ev_t        ev,
  input  logic            rel_clr_i,
  input  logic [PINS-1:0] live_oe_q,
  input  logic [PINS-1:0] live_lat_q,
  input  logic            live_osc_q,
  output logic            rel_q,
  output logic            rel_d,
  output logic            frc_d,
  output logic [PINS-1:0] ret_oe_d,
  output logic [PINS-1:0] ret_lat_d,
  output logic            ret_osc_d
);
  logic            slp_q, slp_d;
  logic            frc_q;
  logic [PINS-1:0] ret_oe_q, ret_lat_q;
  logic            ret_osc_q;

  always_comb begin
    rel_d     = rel_q;
    slp_d     = slp_q;
    frc_d     = frc_q;
    ret_oe_d  = ret_oe_q;
    ret_lat_d = ret_lat_q;
    ret_osc_d = ret_osc_q;
    case (ev)
      EV_BOR: begin
        rel_d     = 1'b0;
        slp_d     = 1'b0;
        frc_d     = 1'b0;
        ret_oe_d  = '0;
        ret_lat_d = '0;
        ret_osc_d = 1'b0;
      end
      EV_PINRST: begin
        slp_d = 1'b0;
        frc_d = rel_q;
      end
      EV_SLEEP: begin
        slp_d = 1'b1;
        rel_d = 1'b1;
        if (!rel_q) begin
          ret_oe_d  = live_oe_q;
          ret_lat_d = live_lat_q;
          ret_osc_d = live_osc_q;
          frc_d     = 1'b0;
        end
      end
      EV_WAKE: slp_d = 1'b0;
      default: begin
        if (rel_clr_i && !slp_q) begin
          rel_d = 1'b0;
          frc_d = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q     <= 1'b0;
      slp_q     <= 1'b0;
      frc_q     <= 1'b0;
      ret_oe_q  <= '0;
      ret_lat_q <= '0;
      ret_osc_q <= 1'b0;
    end else begin
      rel_q     <= rel_d;
      slp_q     <= slp_d;
      frc_q     <= frc_d;
      ret_oe_q  <= ret_oe_d;
      ret_lat_q <= ret_lat_d;
      ret_osc_q <= ret_osc_d;
    end
  end
endmodule

// File: rtl/padhold_ctx.sv
module padhold_ctx
  import padhold_pkg::*;
#(
  parameter int CTX_N = 2,
  parameter int CTX_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  hold_ev_t               ev,
  input  logic [CTX_N-1:0]       we_i,
  input  logic [CTX_W-1:0]       wd_i,
  output logic [CTX_N*CTX_W-1:0] q_o
);
  for (genvar g = 0; g < CTX_N; g++) begin : g_word
    logic [CTX_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst || ev == EV_BOR) word_q <= '0;
      else if (ev == EV_NONE && we_i[g]) word_q <= wd_i;
    end
    assign q_o[g*CTX_W +: CTX_W] = word_q;
  end
endmodule

// File: rtl/padhold_mux.sv
module padhold_mux #(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rel_d,
  input  logic            frc_d,
  input  logic [PINS-1:0] ret_oe_d,
  input  logic [PINS-1:0] ret_lat_d,
  input  logic            ret_osc_d,
  input  logic [PINS-1:0] live_oe_d,
  input  logic [PINS-1:0] live_lat_d,
  input  logic            live_osc_d,
  output logic [PINS-1:0] pad_oe_o,
  output logic [PINS-1:0] pad_do_o,
  output logic            osc_en_o
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic oe_n, do_n;
    always_comb begin
      if (frc_d) begin
        oe_n = 1'b0;
        do_n = 1'b0;
      end else if (rel_d) begin
        oe_n = ret_oe_d[p];
        do_n = ret_lat_d[p] & ret_oe_d[p];
      end else begin
        oe_n = live_oe_d[p];
        do_n = live_lat_d[p] & live_oe_d[p];
      end
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe_o[p] <= 1'b0;
        pad_do_o[p] <= 1'b0;
      end else begin
        pad_oe_o[p] <= oe_n;
        pad_do_o[p] <= do_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) osc_en_o <= 1'b0;
    else     osc_en_o <= rel_d ? ret_osc_d : live_osc_d;
  end
endmodule

// File: rtl/pad_hold_keeper.sv
module pad_hold_keeper
  import padhold_pkg::*;
#(
  parameter int PINS  = 16,
  parameter int CTX_N = 2,
  parameter int CTX_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bor_i,
  input  logic                   pin_rst_i,
  input  logic                   sleep_i,
  input  logic                   wake_i,
  input  logic                   rel_clr_i,
  input  logic                   oe_we_i,
  input  logic [PINS-1:0]        oe_wd_i,
  input  logic                   lat_we_i,
  input  logic [PINS-1:0]        lat_wd_i,
  input  logic                   osc_we_i,
  input  logic                   osc_wd_i,
  input  logic [CTX_N-1:0]       ctx_we_i,
  input  logic [CTX_W-1:0]       ctx_wd_i,
  output logic [CTX_N*CTX_W-1:0] ctx_o,
  output logic [PINS-1:0]        pad_oe_o,
  output logic [PINS-1:0]        pad_do_o,
  output logic                   osc_en_o,
  output logic                   release_o
);
  hold_ev_t        ev;
  logic [PINS-1:0] live_oe_q, live_lat_q, live_oe_d, live_lat_d;
  logic            live_osc_q, live_osc_d;
  logic            rel_d, frc_d, ret_osc_d;
  logic [PINS-1:0] ret_oe_d, ret_lat_d;

  padhold_evt u_evt (
    .bor_i(bor_i), .pin_rst_i(pin_rst_i), .sleep_i(sleep_i),
    .wake_i(wake_i), .ev_o(ev)
  );

  padhold_live #(.PINS(PINS)) u_live (
    .clk(clk), .rst(rst), .ev(ev),
    .oe_we_i(oe_we_i), .oe_wd_i(oe_wd_i),
    .lat_we_i(lat_we_i), .lat_wd_i(lat_wd_i),
    .osc_we_i(osc_we_i), .osc_wd_i(osc_wd_i),
    .oe_q(live_oe_q), .lat_q(live_lat_q), .osc_q(live_osc_q),
    .oe_d(live_oe_d), .lat_d(live_lat_d), .osc_d(live_osc_d)
  );

  padhold_ctrl #(.PINS(PINS)) u_ctrl (
    .clk(clk), .rst(rst), .ev(ev), .rel_clr_i(rel_clr_i),
    .live_oe_q(live_oe_q), .live_lat_q(live_lat_q), .live_osc_q(live_osc_q),
    .rel_q(release_o), .rel_d(rel_d), .frc_d(frc_d),
    .ret_oe_d(ret_oe_d), .ret_lat_d(ret_lat_d), .ret_osc_d(ret_osc_d)
  );

  padhold_ctx #(.CTX_N(CTX_N), .CTX_W(CTX_W)) u_ctx (
    .clk(clk), .rst(rst), .ev(ev),
    .we_i(ctx_we_i), .wd_i(ctx_wd_i), .q_o(ctx_o)
  );

  padhold_mux #(.PINS(PINS)) u_mux (
    .clk(clk), .rst(rst), .rel_d(rel_d), .frc_d(frc_d),
    .ret_oe_d(ret_oe_d), .ret_lat_d(ret_lat_d), .ret_osc_d(ret_osc_d),
    .live_oe_d(live_oe_d), .live_lat_d(live_lat_d), .live_osc_d(live_osc_d),
    .pad_oe_o(pad_oe_o), .pad_do_o(pad_do_o), .osc_en_o(osc_en_o)
  );
endmodule

// File: rtl/padhold_chk.sv
module padhold_chk #(
  parameter int PINS  = 16,
  parameter int CTX_N = 2,
  parameter int CTX_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bor_i,
  input logic                   pin_rst_i,
  input logic                   sleep_i,
  input logic                   rel_clr_i,
  input logic [CTX_N*CTX_W-1:0] ctx_o,
  input logic [PINS-1:0]        pad_oe_o,
  input logic [PINS-1:0]        pad_do_o,
  input logic                   osc_en_o,
  input logic                   release_o
);
  // R1
  a_r1_entry_sets_hold: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && !bor_i && !pin_rst_i) |=> release_o);

  // R2
  a_r2_hold_steady: assert property (@(posedge clk) disable iff (rst)
    (release_o && !bor_i && !pin_rst_i && !sleep_i && !rel_clr_i)
    |=> ($stable(pad_oe_o) && $stable(pad_do_o) && $stable(osc_en_o)));

  // R2
  a_r2_data_gated: assert property (@(posedge clk) disable iff (rst)
    (pad_do_o & ~pad_oe_o) == '0);

  // R6
  a_r6_bor_wipes: assert property (@(posedge clk) disable iff (rst)
    bor_i |=> (!release_o && ctx_o == '0 && pad_oe_o == '0));

  // R7
  a_r7_pin_forces: assert property (@(posedge clk) disable iff (rst)
    (pin_rst_i && !bor_i && release_o)
    |=> (release_o && pad_oe_o == '0 && $stable(osc_en_o)));

  // R8
  a_r8_ctx_kept: assert property (@(posedge clk) disable iff (rst)
    (pin_rst_i && !bor_i) |=> $stable(ctx_o));
endmodule

bind pad_hold_keeper padhold_chk #(.PINS(PINS), .CTX_N(CTX_N), .CTX_W(CTX_W)) u_chk (
  .clk(clk), .rst(rst), .bor_i(bor_i), .pin_rst_i(pin_rst_i),
  .sleep_i(sleep_i), .rel_clr_i(rel_clr_i), .ctx_o(ctx_o),
  .pad_oe_o(pad_oe_o), .pad_do_o(pad_do_o), .osc_en_o(osc_en_o),
  .release_o(release_o)
);

// File: tb/pad_hold_keeper_test.sv
`timescale 1ns/1ps
module pad_hold_keeper_test;
  localparam int PINS = 16;
  localparam int CN   = 2;
  localparam int CW   = 16;

  logic clk = 1'b0;
  logic rst, bor, pinr, slp, wak, rclr, oe_we, lat_we, osc_we, osc_wd;
  logic [PINS-1:0] oe_wd, lat_wd, pad_oe, pad_do;
  logic [CN-1:0]   ctx_we;
  logic [CW-1:0]   ctx_wd;
  logic [CN*CW-1:0] ctx;
  logic osc_en, rel;

  int checks = 0;
  int errors = 0;

  // model state
  logic [PINS-1:0] m_loe, m_llat, m_roe, m_rlat;
  logic m_losc, m_rosc, m_rel, m_frc, m_slp;
  logic [CW-1:0] m_ctx [CN];

  always #10 clk = ~clk;

  pad_hold_keeper #(.PINS(PINS), .CTX_N(CN), .CTX_W(CW)) uut (
    .clk(clk), .rst(rst), .bor_i(bor), .pin_rst_i(pinr), .sleep_i(slp),
    .wake_i(wak), .rel_clr_i(rclr), .oe_we_i(oe_we), .oe_wd_i(oe_wd),
    .lat_we_i(lat_we), .lat_wd_i(lat_wd), .osc_we_i(osc_we), .osc_wd_i(osc_wd),
    .ctx_we_i(ctx_we), .ctx_wd_i(ctx_wd), .ctx_o(ctx),
    .pad_oe_o(pad_oe), .pad_do_o(pad_do), .osc_en_o(osc_en), .release_o(rel)
  );

  function automatic logic [PINS-1:0] exp_oe();
    if (m_frc) return '0;
    return m_rel ? m_roe : m_loe;
  endfunction

  function automatic logic [PINS-1:0] exp_do();
    if (m_frc) return '0;
    return m_rel ? (m_rlat & m_roe) : (m_llat & m_loe);
  endfunction

  function automatic logic exp_osc();
    return m_rel ? m_rosc : m_losc;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    bor = 0; pinr = 0; slp = 0; wak = 0; rclr = 0;
    oe_we = 0; lat_we = 0; osc_we = 0; ctx_we = '0;
    oe_wd = '0; lat_wd = '0; osc_wd = 0; ctx_wd = '0;
  endtask

  task automatic model_reset();
    m_loe = '0; m_llat = '0; m_roe = '0; m_rlat = '0;
    m_losc = 0; m_rosc = 0; m_rel = 0; m_frc = 0; m_slp = 0;
    for (int i = 0; i < CN; i++) m_ctx[i] = '0;
  endtask

  // expected next state from the requirements (R1..R10)
  task automatic model_step();
    if (bor) begin
      model_reset();
    end else if (pinr) begin
      m_loe = '0; m_llat = '0; m_losc = 0;
      m_frc = m_rel; m_slp = 0;
    end else if (slp) begin
      if (!m_rel) begin
        m_roe = m_loe; m_rlat = m_llat; m_rosc = m_losc; m_frc = 0;
      end
      m_rel = 1; m_slp = 1;
    end else if (wak) begin
      m_slp = 0; m_loe = '0; m_llat = '0; m_losc = 0;
    end else begin
      if (rclr && !m_slp) begin m_rel = 0; m_frc = 0; end
      if (oe_we)  m_loe  = oe_wd;
      if (lat_we) m_llat = lat_wd;
      if (osc_we) m_losc = osc_wd;
      for (int i = 0; i < CN; i++) if (ctx_we[i]) m_ctx[i] = ctx_wd;
    end
  endtask

  // inputs already set at a negedge; clock once, then check at next negedge
  task automatic step(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " pad_oe"}, 64'(pad_oe), 64'(exp_oe()));
    chk({tag, " pad_do"}, 64'(pad_do), 64'(exp_do()));
    chk({tag, " osc_en"}, 64'(osc_en), 64'(exp_osc()));
    chk({tag, " release"}, 64'(rel), 64'(m_rel));
    for (int i = 0; i < CN; i++)
      chk({tag, " ctx"}, 64'(ctx[i*CW +: CW]), 64'(m_ctx[i]));
    idle_inputs();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    idle_inputs();
    rst = 1;
    model_reset();
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R9: reset state
    chk("R9 pad_oe", 64'(pad_oe), 0);
    chk("R9 release", 64'(rel), 0);
    chk("R9 ctx", 64'(ctx), 0);

    // R8 context write, R4-style live setup
    ctx_we = 2'b11; ctx_wd = 16'hBEEF; oe_we = 1; oe_wd = 16'h00FF;
    lat_we = 1; lat_wd = 16'h0F0F; osc_we = 1; osc_wd = 1;
    step("R8");
    // R1 entry, with an ignored write in the same cycle (R10)
    slp = 1; oe_we = 1; oe_wd = 16'hFFFF; step("R1");
    // R2 writes while asleep do not reach pads
    oe_we = 1; oe_wd = 16'hA5A5; lat_we = 1; lat_wd = 16'hFFFF; step("R2");
    // R4 release ignored while asleep
    rclr = 1; step("R4");
    // R3 wake keeps retained pads, resets live
    wak = 1; step("R3");
    // R5 set live osc and pins before release, then release
    osc_we = 1; osc_wd = 1; oe_we = 1; oe_wd = 16'h3C3C; lat_we = 1; lat_wd = 16'h1111;
    step("R5");
    rclr = 1; step("R4");
    chk("R5 osc_stays_on", 64'(osc_en), 1);
    // R7 pin reset during sleep
    ctx_we = 2'b01; ctx_wd = 16'h1234; step("R8");
    slp = 1; step("R1");
    pinr = 1; step("R7");
    oe_we = 1; oe_wd = 16'hFFFF; lat_we = 1; lat_wd = 16'hFFFF; step("R7");
    rclr = 1; step("R7");
    // R6 brown-out during sleep wipes context
    slp = 1; step("R1");
    bor = 1; step("R6");
    // R10 simultaneous events, brown-out wins
    ctx_we = 2'b10; ctx_wd = 16'h7777; step("R8");
    slp = 1; step("R1");
    bor = 1; pinr = 1; slp = 1; step("R10");
    // R10 pin reset beats sleep
    oe_we = 1; oe_wd = 16'h8001; step("R10");
    slp = 1; step("R1");
    pinr = 1; slp = 1; wak = 1; ctx_we = 2'b11; ctx_wd = 16'h5555; step("R10");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      int r;
      string tag;
      r = $urandom % 100;
      oe_we = $urandom % 2; oe_wd = PINS'($urandom);
      lat_we = $urandom % 2; lat_wd = PINS'($urandom);
      osc_we = ($urandom % 4) == 0; osc_wd = $urandom % 2;
      ctx_we = CN'($urandom); ctx_wd = CW'($urandom);
      if (r < 3)       begin bor = 1;  tag = "R6"; end
      else if (r < 8)  begin pinr = 1; tag = "R7"; end
      else if (r < 18) begin slp = 1;  tag = "R1"; end
      else if (r < 28) begin wak = 1;  tag = "R3"; end
      else if (r < 40) begin rclr = 1; tag = "R4"; end
      else             tag = "R2";
      if (($urandom % 20) == 0) begin bor = $urandom % 2; pinr = 1; tag = "R10"; end
      step(tag);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule